// File: doc/BRIEF.md
# Configurable Clock Tree Controller

This block derives two clock-enable streams for a synchronous core from a set of incoming clock events. One stream is the internal peripheral clock enable and the other is the CPU clock enable. It also produces a fixed timer tick. All outputs are single-cycle enable pulses in one fast system clock domain, so no clock is ever gated.

The main oscillator arrives as a tick pulse. It can be halved to form the reference event stream. The internal clock then comes from one of two places: the output of an external frequency multiplier, passed through a 1-to-7 post-divider, or the reference divided by 16 when the multiplier is bypassed. A slow asynchronous alternate clock can replace the whole main path. Changing to or from it goes through a handshaked state machine, so no partial period ever reaches the output. The CPU enable is a further division of the internal enable by 1 to 8. A divide-by-128 tap of the reference feeds a timer.

Settings live in an 11-bit configuration register written through `cfg_wr_i`. Fields of `cfg_wdata_i`:
- bit 0: alternate-source request.
- bit 1: multiplier enable.
- bits 3:2: multiplier factor code.
- bit 4: halving enable.
- bits 7:5: post-divider ratio.
- bits 10:8: CPU prescaler code.

The source-switch machine has eight states:
- SW_MAIN: the main path drives the output.
- SW_HS1_ALT, SW_HS2_ALT: handshake toward the alternate clock.
- SW_ARM_ALT: waiting for an aligning alternate edge.
- SW_ALT: the alternate clock drives the output.
- SW_HS1_MAIN, SW_HS2_MAIN: handshake back toward the main path.
- SW_ARM_MAIN: waiting for an aligning main pulse.

Transitions:
- SW_MAIN goes to SW_HS1_ALT on a main pulse while the request is set.
- The handshake states advance one per cycle.
- SW_ARM_ALT goes to SW_ALT on an alternate edge.
- SW_ALT goes to SW_HS1_MAIN on an alternate edge while the request is clear.
- SW_ARM_MAIN goes to SW_MAIN on a main pulse.

Top module: `clkt_tree`

## Requirements
- R1: After reset, the outputs and settings are as follows.
  - Outputs: mul_en_o=0, mul_sel_o=0, src_alt_o=0 and osc_stop_ok_o=0.
  - Settings: halving on, multiplier bypassed, post-divider at 1, CPU prescaler at 1.
  - Result: with an oscillator tick every cycle, int_ce_o pulses every 32 cycles.
- R2: A write with cfg_wr_i=1 stores cfg_wdata_i, and the new setting takes effect from the next cycle.
  - mul_en_o mirrors bit 1 and mul_sel_o mirrors bits 3:2.
  - Factor codes: 00 means x6, 01 x8, 10 x10, 11 x14.
  - Neither output changes without a write.
- R3: A reference event occurs as follows.
  - Halving off (bit 4 = 0): on every osc_tick_i.
  - Halving on: on every second osc_tick_i, counting from reset (the 2nd, 4th, ...).
- R4: tmr_tick_o pulses in the cycle of every 128th reference event.
- R5: With the multiplier bypassed (bit 1 = 0) and the main path selected, int_ce_o pulses in the cycle of every 16th reference event.
- R6: With the multiplier enabled and the main path selected, int_ce_o pulses on every Nth mul_tick_i, where N is bits 7:5 and a value of 0 means 1.
- R7: A new post-divider ratio is taken only when the divider reaches its terminal count. The period already under way completes with the old ratio.
- R8: cpu_ce_o pulses together with every (N+1)th int_ce_o, where N is bits 10:8. A new N is taken only when the prescaler wraps.
- R9: Switching to the alternate source (bit 0 set) happens in this order:
  - the main path keeps driving up to and including its next pulse;
  - two quiet handshake cycles follow;
  - the first alternate rising edge seen after them is suppressed;
  - from then on, every alternate rising edge gives one int_ce_o, two cycles after the edge is first sampled.
- R10: src_alt_o changes only at the end of a handshake: it rises entering SW_ALT and falls entering SW_MAIN. osc_stop_ok_o is 1 only in SW_ALT while bit 0 is still set.
- R11: Switching back (bit 0 cleared) is symmetric:
  - the alternate clock drives up to and including its next edge;
  - two quiet cycles follow;
  - the first main pulse after them is suppressed;
  - the main path drives from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | One pulse per main oscillator period |
| mul_tick_i | input | 1 | One pulse per multiplied clock period |
| alt_clk_i | input | 1 | Slow alternate clock level, asynchronous |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 11 | Configuration word |
| mul_en_o | output | 1 | Multiplier enable to the external multiplier |
| mul_sel_o | output | 2 | Multiplier factor code to the external multiplier |
| int_ce_o | output | 1 | Internal peripheral clock enable |
| cpu_ce_o | output | 1 | CPU clock enable |
| tmr_tick_o | output | 1 | Reference divided by 128 timer tick |
| src_alt_o | output | 1 | The alternate clock drives the internal clock |
| osc_stop_ok_o | output | 1 | The main oscillator may be stopped |

## Verification
The hardest situation to reach from the ports is a source-select write that lands at an arbitrary point of the old source's period. The matching case in the other direction is a request that is withdrawn while the handshake toward the alternate clock is still in progress. Neither can be arranged by timing a single directed write. The stimulus therefore rewrites the configuration, with a random select bit, at random intervals. It also uses sparse, random oscillator and multiplier ticks and alternate clock half-periods of three to ten cycles. Every cycle is compared against a bench model of the enable streams. Directed runs with a tick on every cycle then pin down the exact halving, bypass and mid-period ratio-change intervals.

// File: rtl/clkt_pkg.sv
package clkt_pkg;

    localparam int DIV_W = 3;
    localparam int CFG_W = 11;

    typedef struct packed {
        logic [DIV_W-1:0] cpu_div;
        logic [DIV_W-1:0] post_div;
        logic             halve;
        logic [1:0]       mul_sel;
        logic             mul_en;
        logic             alt_sel;
    } clkt_cfg_t;

    localparam clkt_cfg_t CFG_RST = '{cpu_div: '0, post_div: 3'd1, halve: 1'b1,
                                      mul_sel: 2'd0, mul_en: 1'b0, alt_sel: 1'b0};

    typedef enum logic [2:0] {
        SW_MAIN,
        SW_HS1_ALT,
        SW_HS2_ALT,
        SW_ARM_ALT,
        SW_ALT,
        SW_HS1_MAIN,
        SW_HS2_MAIN,
        SW_ARM_MAIN
    } sw_state_t;

endpackage

// File: rtl/clkt_refgen.sv
module clkt_refgen #(
    parameter int FAST_TAP = 16,
    parameter int SLOW_TAP = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick_i,
    input  logic halve_i,
    output logic fast_o,
    output logic slow_o
);
    localparam int CNT_W  = $clog2(SLOW_TAP);
    localparam int FAST_W = $clog2(FAST_TAP);

    logic             phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ref_ce;

    // phase toggles on every oscillator tick; a halved reference takes odd phases only
    assign ref_ce = osc_tick_i & (phase_q | ~halve_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (osc_tick_i) phase_q <= ~phase_q;
            if (ref_ce)     cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        fast_o = ref_ce & (&cnt_q[FAST_W-1:0]);
        slow_o = ref_ce & (&cnt_q);
    end

endmodule

// File: rtl/clkt_ratio_div.sv
module clkt_ratio_div #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] lim_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;

    assign hit_o = tick_i & (cnt_q == lim_q);

    // the limit is only reloaded at terminal count, so a running period completes unchanged
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == lim_q) begin
                cnt_q <= '0;
                lim_q <= lim_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkt_src_switch.sv
module clkt_src_switch
    import clkt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_pulse_i,
    input  logic alt_clk_i,
    input  logic req_alt_i,
    output logic ce_o,
    output logic src_alt_o,
    output logic stop_ok_o
);
    logic [SYNC_STAGES:0] alt_sh_q;
    logic                 alt_pulse;
    sw_state_t            state_q;
    sw_state_t            state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alt_sh_q <= '0;
        else        alt_sh_q <= {alt_sh_q[SYNC_STAGES-1:0], alt_clk_i};
    end

    assign alt_pulse = alt_sh_q[SYNC_STAGES-1] & ~alt_sh_q[SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_MAIN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_MAIN:     if (req_alt_i && main_pulse_i) state_d = SW_HS1_ALT;
            SW_HS1_ALT:  state_d = SW_HS2_ALT;
            SW_HS2_ALT:  state_d = SW_ARM_ALT;
            SW_ARM_ALT:  if (alt_pulse) state_d = SW_ALT;
            SW_ALT:      if (!req_alt_i && alt_pulse) state_d = SW_HS1_MAIN;
            SW_HS1_MAIN: state_d = SW_HS2_MAIN;
            SW_HS2_MAIN: state_d = SW_ARM_MAIN;
            SW_ARM_MAIN: if (main_pulse_i) state_d = SW_MAIN;
            default:     state_d = SW_MAIN;
        endcase
    end

    always_comb begin
        ce_o      = 1'b0;
        src_alt_o = 1'b0;
        stop_ok_o = 1'b0;
        unique case (state_q)
            SW_MAIN:     ce_o = main_pulse_i;
            SW_HS1_ALT,
            SW_HS2_ALT,
            SW_ARM_ALT:  ce_o = 1'b0;
            SW_ALT: begin
                ce_o      = alt_pulse;
                src_alt_o = 1'b1;
                stop_ok_o = req_alt_i;
            end
            SW_HS1_MAIN,
            SW_HS2_MAIN,
            SW_ARM_MAIN: src_alt_o = 1'b1;
            default:     ce_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkt_tree.sv
module clkt_tree
    import clkt_pkg::*;
#(
    parameter int FAST_TAP    = 16,
    parameter int SLOW_TAP    = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick_i,
    input  logic             mul_tick_i,
    input  logic             alt_clk_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             mul_en_o,
    output logic [1:0]       mul_sel_o,
    output logic             int_ce_o,
    output logic             cpu_ce_o,
    output logic             tmr_tick_o,
    output logic             src_alt_o,
    output logic             osc_stop_ok_o
);
    clkt_cfg_t        cfg_q;
    logic             fast_tick;
    logic             slow_tick;
    logic [DIV_W-1:0] post_lim;
    logic             post_hit;
    logic             main_pulse;
    logic             int_ce;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_q <= CFG_RST;
        else if (cfg_wr_i) cfg_q <= clkt_cfg_t'(cfg_wdata_i);
    end

    clkt_refgen #(.FAST_TAP(FAST_TAP), .SLOW_TAP(SLOW_TAP)) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick_i (osc_tick_i),
        .halve_i    (cfg_q.halve),
        .fast_o     (fast_tick),
        .slow_o     (slow_tick)
    );

    // ratio 0 behaves as ratio 1
    assign post_lim = (cfg_q.post_div == '0) ? '0 : cfg_q.post_div - 1'b1;

    clkt_ratio_div #(.W(DIV_W)) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (mul_tick_i),
        .lim_i  (post_lim),
        .hit_o  (post_hit)
    );

    assign main_pulse = cfg_q.mul_en ? post_hit : fast_tick;

    clkt_src_switch #(.SYNC_STAGES(SYNC_STAGES)) u_sw (
        .clk          (clk),
        .rst_n        (rst_n),
        .main_pulse_i (main_pulse),
        .alt_clk_i    (alt_clk_i),
        .req_alt_i    (cfg_q.alt_sel),
        .ce_o         (int_ce),
        .src_alt_o    (src_alt_o),
        .stop_ok_o    (osc_stop_ok_o)
    );

    clkt_ratio_div #(.W(DIV_W)) u_cpu (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (int_ce),
        .lim_i  (cfg_q.cpu_div),
        .hit_o  (cpu_ce_o)
    );

    always_comb begin
        int_ce_o   = int_ce;
        tmr_tick_o = slow_tick;
        mul_en_o   = cfg_q.mul_en;
        mul_sel_o  = cfg_q.mul_sel;
    end

endmodule

// File: rtl/clkt_tree_chk.sv
module clkt_tree_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr_i,
    input logic       int_ce_o,
    input logic       cpu_ce_o,
    input logic       tmr_tick_o,
    input logic       src_alt_o,
    input logic       osc_stop_ok_o,
    input logic       mul_en_o,
    input logic [1:0] mul_sel_o
);
    // R8: the CPU enable is a subset of the internal enable
    a_r8_cpu_in_int: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ce_o |-> int_ce_o);

    // R4: timer tick is never held for two cycles
    a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tick_o |=> !tmr_tick_o);

    // R10: stopping the oscillator is allowed only while the alternate source drives
    a_r10_stop_only_alt: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop_ok_o |-> src_alt_o);

    // R9: the cycle before the alternate source takes over carries no enable
    a_r9_no_runt_in: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_alt_o) |-> !$past(int_ce_o));

    // R11: the cycle before the main path takes over carries no enable
    a_r11_no_runt_back: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(src_alt_o) |-> !$past(int_ce_o));

    // R2: multiplier controls move only after a write
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_wr_i) |-> ($stable(mul_sel_o) && $stable(mul_en_o)));

endmodule

bind clkt_tree clkt_tree_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_i      (cfg_wr_i),
    .int_ce_o      (int_ce_o),
    .cpu_ce_o      (cpu_ce_o),
    .tmr_tick_o    (tmr_tick_o),
    .src_alt_o     (src_alt_o),
    .osc_stop_ok_o (osc_stop_ok_o),
    .mul_en_o      (mul_en_o),
    .mul_sel_o     (mul_sel_o)
);

// File: tb/tb_clkt_tree.sv
module tb_clkt_tree;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick_i = 1'b0;
    logic        mul_tick_i = 1'b0;
    logic        alt_clk_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [10:0] cfg_wdata_i = '0;
    logic        mul_en_o;
    logic [1:0]  mul_sel_o;
    logic        int_ce_o;
    logic        cpu_ce_o;
    logic        tmr_tick_o;
    logic        src_alt_o;
    logic        osc_stop_ok_o;

    clkt_tree dut (
        .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick_i), .mul_tick_i(mul_tick_i),
        .alt_clk_i(alt_clk_i), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
        .mul_en_o(mul_en_o), .mul_sel_o(mul_sel_o), .int_ce_o(int_ce_o),
        .cpu_ce_o(cpu_ce_o), .tmr_tick_o(tmr_tick_o), .src_alt_o(src_alt_o),
        .osc_stop_ok_o(osc_stop_ok_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // bench model state
    bit       m_half, m_alt, m_men, m_halve;
    bit [1:0] m_msel;
    bit [2:0] m_post, m_cpu, m_pdc, m_pdl, m_cpc, m_cpl;
    bit [6:0] m_ref;
    bit       m_a1, m_a2, m_a3;
    int       m_st;
    // alternate clock generator
    bit       alt_lvl;
    int       alt_half = 5;
    int       alt_cnt = 0;
    int       last_int = 0;
    int       prev_int = 0;

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [10:0] pack(bit alt, bit men, bit [1:0] msel, bit halve,
                                         bit [2:0] post, bit [2:0] cpu);
        return {cpu, post, halve, msel, men, alt};
    endfunction

    function automatic bit [2:0] post_limit(bit [2:0] v);
        return (v == 3'd0) ? 3'd0 : v - 3'd1;
    endfunction

    task automatic model_reset();
        m_half = 0; m_ref = 0; m_pdc = 0; m_pdl = 0; m_cpc = 0; m_cpl = 0;
        m_a1 = 0; m_a2 = 0; m_a3 = 0; m_st = 0;
        m_alt = 0; m_men = 0; m_msel = 0; m_halve = 1; m_post = 3'd1; m_cpu = 0;
    endtask

    task automatic step(input bit osc, input bit mul, input bit wr, input logic [10:0] wd);
        bit ref_e, t16, t128, pdh, mainp, altp, e_int, e_cpu;
        int nst;
        string tag;
        @(negedge clk);
        alt_cnt++;
        if (alt_cnt >= alt_half) begin
            alt_cnt = 0;
            alt_lvl = ~alt_lvl;
        end
        osc_tick_i = osc; mul_tick_i = mul; cfg_wr_i = wr; cfg_wdata_i = wd;
        alt_clk_i = alt_lvl;
        #1;
        cyc++;
        ref_e = osc && (m_half || !m_halve);
        t16   = ref_e && (m_ref[3:0] == 4'hF);
        t128  = ref_e && (m_ref == 7'h7F);
        pdh   = mul && (m_pdc == m_pdl);
        mainp = m_men ? pdh : t16;
        altp  = m_a2 && !m_a3;
        e_int = (m_st == 0) ? mainp : ((m_st == 4) ? altp : 1'b0);
        e_cpu = e_int && (m_cpc == m_cpl);
        if (m_st == 0)      tag = m_men ? "R6" : "R5";
        else if (m_st <= 4) tag = "R9";
        else                tag = "R11";
        chk(int_ce_o, e_int, tag, "int_ce");
        chk(cpu_ce_o, e_cpu, "R8", "cpu_ce");
        chk(tmr_tick_o, t128, "R4", "tmr_tick");
        chk(src_alt_o, m_st >= 4, "R10", "src_alt");
        chk(osc_stop_ok_o, (m_st == 4) && m_alt, "R10", "stop_ok");
        chk(mul_en_o, m_men, "R2", "mul_en");
        chk_int(int'(mul_sel_o), int'(m_msel), "R2", "mul_sel");
        if (int_ce_o) begin
            prev_int = last_int;
            last_int = cyc;
        end
        // next state of the model
        nst = m_st;
        case (m_st)
            0: if (m_alt && mainp) nst = 1;
            1: nst = 2;
            2: nst = 3;
            3: if (altp) nst = 4;
            4: if (!m_alt && altp) nst = 5;
            5: nst = 6;
            6: nst = 7;
            7: if (mainp) nst = 0;
            default: nst = 0;
        endcase
        m_st = nst;
        if (osc) m_half = ~m_half;
        if (ref_e) m_ref = m_ref + 7'd1;
        if (mul) begin
            if (pdh) begin m_pdc = 0; m_pdl = post_limit(m_post); end
            else m_pdc = m_pdc + 3'd1;
        end
        if (e_int) begin
            if (m_cpc == m_cpl) begin m_cpc = 0; m_cpl = m_cpu; end
            else m_cpc = m_cpc + 3'd1;
        end
        m_a3 = m_a2; m_a2 = m_a1; m_a1 = alt_lvl;
        if (wr) begin
            {m_cpu, m_post, m_halve, m_msel, m_men, m_alt} = wd;
        end
    endtask

    task automatic idle_write(input logic [10:0] wd);
        step(1'b0, 1'b0, 1'b1, wd);
    endtask

    // step with every tick present until the next internal enable
    task automatic wait_int();
        int start;
        start = last_int;
        for (int i = 0; i < 200; i++) begin
            if (last_int != start) break;
            step(1'b1, 1'b1, 1'b0, '0);
        end
    endtask

    task automatic run_random(input int n, input int p_osc, input int p_mul);
        for (int i = 0; i < n; i++) begin
            step(($urandom % 100) < p_osc, ($urandom % 100) < p_mul, 1'b0, '0);
        end
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5107));
        alt_lvl = 0;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports
        #1;
        chk(mul_en_o, 1'b0, "R1", "mul_en reset");
        chk_int(int'(mul_sel_o), 0, "R1", "mul_sel reset");
        chk(src_alt_o, 1'b0, "R1", "src_alt reset");
        chk(osc_stop_ok_o, 1'b0, "R1", "stop_ok reset");
        chk(int_ce_o, 1'b0, "R1", "int_ce reset");

        // R1: default path is halved reference divided by 16
        wait_int(); wait_int();
        chk_int(last_int - prev_int, 32, "R1", "default int gap");

        // R3: halving off gives 16 cycles, halving on gives 32
        idle_write(pack(0, 0, 2'd0, 0, 3'd1, 3'd0));
        wait_int(); wait_int(); wait_int();
        chk_int(last_int - prev_int, 16, "R3", "gap without halving");
        idle_write(pack(0, 0, 2'd0, 1, 3'd1, 3'd0));
        wait_int(); wait_int(); wait_int();
        chk_int(last_int - prev_int, 32, "R3", "gap with halving");

        // R6: post-divider ratio 0 behaves as 1, ratio 5 gives 5
        idle_write(pack(0, 1, 2'd3, 1, 3'd0, 3'd0));
        wait_int(); wait_int(); wait_int();
        chk_int(last_int - prev_int, 1, "R6", "ratio 0 gap");
        idle_write(pack(0, 1, 2'd2, 1, 3'd5, 3'd0));
        wait_int(); wait_int(); wait_int();
        chk_int(last_int - prev_int, 5, "R6", "ratio 5 gap");

        // R7: ratio change mid period takes effect at terminal count
        idle_write(pack(0, 1, 2'd1, 1, 3'd7, 3'd0));
        wait_int(); wait_int(); wait_int();
        step(1'b1, 1'b1, 1'b0, '0);
        step(1'b1, 1'b1, 1'b1, pack(0, 1, 2'd1, 1, 3'd2, 3'd0));
        wait_int();
        chk_int(last_int - prev_int, 7, "R7", "period after mid-count write");
        wait_int();
        chk_int(last_int - prev_int, 2, "R7", "first period with new ratio");

        // R8: CPU prescaler 7 gives every 8th internal enable
        idle_write(pack(0, 1, 2'd0, 1, 3'd1, 3'd7));
        run_random(200, 100, 100);

        // R9/R11: directed switch to the alternate clock and back
        alt_half = 4;
        idle_write(pack(1, 0, 2'd0, 0, 3'd1, 3'd0));
        run_random(400, 100, 50);
        chk(src_alt_o, 1'b1, "R9", "switched to alternate");
        idle_write(pack(0, 0, 2'd0, 0, 3'd1, 3'd0));
        run_random(400, 100, 50);
        chk(src_alt_o, 1'b0, "R11", "switched back to main");

        // mixed random configurations, including random source requests
        for (int seg = 0; seg < 60; seg++) begin
            logic [10:0] w;
            w = 11'($urandom);
            alt_half = 3 + int'($urandom % 8);
            idle_write(w);
            run_random(200 + int'($urandom % 800), 30 + int'($urandom % 71),
                       20 + int'($urandom % 81));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule